// File: doc/BRIEF.md
# Paged auto-increment byte memory

This block is a byte-wide memory that software never addresses directly. The host first loads a 16-bit address register by writing two bytes, high byte first. After that it streams bytes in or out through a data register that always holds the next byte, fetched ahead of time. Each data access moves the address forward by one. The low 13 bits of the address index a 6144-byte array. The top 3 bits form a page-select field. Several copies of the block can sit in parallel on one bus, each with its own fixed page number, and they stay in step because every copy performs every register update. Only the copy whose page number matches the page field drives data onto the bus.

An access starts when chip enable goes low. Two mode lines then choose the target and the direction. `mode_addr_i` is 1 for the address register and 0 for the data register. `mode_rd_i` is 1 for a read and 0 for a write. The block is paced by a slow device-clock enable `tick_i`, and `ready_o` signals that the byte has been taken or is valid on the bus. The storage is RAM, so the write-data access fills the array and no preload is needed.

Top module: `pbm_top`

## Requirements
- R1: After the asynchronous reset `ready_o` and `data_oe_o` are 0, the address and data registers are 0, and the pair flag is cleared, so the first address write after reset is the first byte of a pair.
- R2: Each address write (`mode_addr_i`=1, `mode_rd_i`=0) moves the old address low byte into the high byte and loads the bus byte into the low byte.
- R3: An address write that directly follows another address write that began a pair completes the pair. It loads the data register with the byte at the new address and then increments the address. An address write that follows any other access starts a new pair and does neither.
- R4: A data read (`mode_addr_i`=0, `mode_rd_i`=1) returns the data register, then increments the address and loads the data register with the byte at the incremented address.
- R5: A data read drives the bus (`data_oe_o`=1) only when address bits [15:13] equal `PAGE_ID` (default 5). READY, the increment and the prefetch happen whatever the page.
- R6: An address read (`mode_addr_i`=1, `mode_rd_i`=1) returns address bits [15:8] with `data_oe_o`=1 whatever the page, then copies the low byte into the high byte.
- R7: Every increment changes only address bits [12:0], wraps from 8191 to 0, and leaves bits [15:13] unchanged.
- R8: A data write (`mode_addr_i`=0, `mode_rd_i`=0) stores the bus byte at the array index given by address bits [12:0], then increments the address. An index of 6144 or more maps to index minus 6144.
- R9: `ready_o` rises after exactly `READY_TICKS` (default 2) clock edges with `tick_i` high. Counting starts at the edge after the one where the block first sees `ce_ni` low. `ready_o` then stays high while `ce_ni` is low, falls at the first edge that sees `ce_ni` high, and is low while `ce_ni` stays high.
- R10: `data_oe_o` is 1 only while `ready_o` is high during a read; it is 0 during write accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Device clock enable, one cycle per device tick |
| ce_ni | input | 1 | Chip enable, active low; a falling level starts an access |
| mode_addr_i | input | 1 | 1 selects the address register, 0 the data register |
| mode_rd_i | input | 1 | 1 for read, 0 for write |
| data_i | input | 8 | Bus byte in |
| data_o | output | 8 | Bus byte out |
| data_oe_o | output | 1 | Drive enable for `data_o` |
| ready_o | output | 1 | Access acknowledged |

## Verification
The assertions assume that `ce_ni`, the mode lines and `data_i` stay stable from the fall of chip enable until `ready_o` has dropped again. They also assume each access ends with `ce_ni` high for at least one clock. The bench sets all access inputs at a falling clock edge before it lowers `ce_ni`, holds them until it has raised `ce_ni` and seen `ready_o` low, and leaves an idle cycle before the next access. It never aborts an access before READY.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  // encoding is {addr-select, read}
  typedef enum logic [1:0] {
    OP_WR_DATA = 2'b00,
    OP_RD_DATA = 2'b01,
    OP_WR_ADDR = 2'b10,
    OP_RD_ADDR = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACT  = 2'd2
  } state_e;
endpackage

// File: rtl/pbm_ctrl.sv
module pbm_ctrl
  import pbm_pkg::*;
#(
  parameter int READY_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ce_ni,
  input  logic mode_addr_i,
  input  logic mode_rd_i,
  output op_e  op_o,
  output logic exec_o,
  output logic pair_hit_o,
  output logic ready_o
);
  localparam int CW = (READY_TICKS > 1) ? $clog2(READY_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(READY_TICKS - 1);

  state_e        state_q;
  logic [CW-1:0] cnt_q;
  op_e           op_q;
  logic          pair_q;

  assign exec_o     = (state_q == ST_WAIT) && !ce_ni && tick_i && (cnt_q == LAST);
  assign pair_hit_o = pair_q && (op_q == OP_WR_ADDR);
  assign op_o       = op_q;
  assign ready_o    = (state_q == ST_ACT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      op_q    <= OP_WR_DATA;
      pair_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (!ce_ni) begin
            op_q    <= op_e'({mode_addr_i, mode_rd_i});
            cnt_q   <= '0;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (ce_ni) begin
            state_q <= ST_IDLE;  // aborted access has no effect
          end else if (tick_i) begin
            if (cnt_q == LAST) begin
              state_q <= ST_ACT;
              // second address write closes the pair, anything else resets it
              pair_q  <= (op_q == OP_WR_ADDR) ? !pair_q : 1'b0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_ACT: begin
          if (ce_ni) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pbm_addr.sv
module pbm_addr
  import pbm_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int IW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          exec_i,
  input  op_e           op_i,
  input  logic          pair_hit_i,
  input  logic [DW-1:0] byte_i,
  output logic [AW-1:0] addr_o,
  output logic [IW-1:0] fetch_idx_o
);
  logic [AW-1:0] addr_q;
  logic [AW-1:0] loaded;
  logic [IW-1:0] low_inc;
  logic [IW-1:0] loaded_inc;

  assign loaded     = {addr_q[DW-1:0], byte_i};
  assign low_inc    = addr_q[IW-1:0] + IW'(1);
  assign loaded_inc = loaded[IW-1:0] + IW'(1);
  assign addr_o     = addr_q;

  // read-data fetches after the increment, a closing address write before it
  always_comb begin
    if (op_i == OP_RD_DATA) fetch_idx_o = low_inc;
    else                    fetch_idx_o = loaded[IW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (exec_i) begin
      unique case (op_i)
        OP_WR_ADDR: addr_q <= pair_hit_i ? {loaded[AW-1:IW], loaded_inc} : loaded;
        OP_RD_ADDR: addr_q[AW-1:DW] <= addr_q[DW-1:0];
        OP_RD_DATA,
        OP_WR_DATA: addr_q[IW-1:0] <= low_inc;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pbm_array.sv
module pbm_array #(
  parameter int DEPTH = 6144,
  parameter int IW    = 13,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rdata_o
);
  logic [IW-1:0] wr_f;
  logic [IW-1:0] rd_f;
  logic [DW-1:0] mem_q [DEPTH];

  // index space larger than the array: fold the top back by one depth
  if (DEPTH < (1 << IW)) begin : g_fold
    assign wr_f = (wr_idx_i >= IW'(DEPTH)) ? wr_idx_i - IW'(DEPTH) : wr_idx_i;
    assign rd_f = (rd_idx_i >= IW'(DEPTH)) ? rd_idx_i - IW'(DEPTH) : rd_idx_i;
  end else begin : g_flat
    assign wr_f = wr_idx_i;
    assign rd_f = rd_idx_i;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wr_f] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_f];
endmodule

// File: rtl/pbm_top.sv
module pbm_top
  import pbm_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter int              DATA_W      = 8,
  parameter int              PAGE_W      = 3,
  parameter int              DEPTH       = 6144,
  parameter int              READY_TICKS = 2,
  parameter logic [PAGE_W-1:0] PAGE_ID   = 3'd5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ce_ni,
  input  logic              mode_addr_i,
  input  logic              mode_rd_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              ready_o
);
  localparam int IDX_W = ADDR_W - PAGE_W;

  op_e               op;
  logic              exec;
  logic              pair_hit;
  logic [ADDR_W-1:0] addr;
  logic [IDX_W-1:0]  fetch_idx;
  logic [DATA_W-1:0] rdata;
  logic [DATA_W-1:0] dreg_q;
  logic [DATA_W-1:0] out_q;
  logic              oe_q;
  logic              page_hit;

  pbm_ctrl #(.READY_TICKS(READY_TICKS)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .ce_ni       (ce_ni),
    .mode_addr_i (mode_addr_i),
    .mode_rd_i   (mode_rd_i),
    .op_o        (op),
    .exec_o      (exec),
    .pair_hit_o  (pair_hit),
    .ready_o     (ready_o)
  );

  pbm_addr #(.AW(ADDR_W), .DW(DATA_W), .IW(IDX_W)) i_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exec_i      (exec),
    .op_i        (op),
    .pair_hit_i  (pair_hit),
    .byte_i      (data_i),
    .addr_o      (addr),
    .fetch_idx_o (fetch_idx)
  );

  pbm_array #(.DEPTH(DEPTH), .IW(IDX_W), .DW(DATA_W)) i_array (
    .clk_i    (clk_i),
    .we_i     (exec && (op == OP_WR_DATA)),
    .wr_idx_i (addr[IDX_W-1:0]),
    .wdata_i  (data_i),
    .rd_idx_i (fetch_idx),
    .rdata_o  (rdata)
  );

  assign page_hit = (addr[ADDR_W-1 -: PAGE_W] == PAGE_ID);

  // bus byte is captured at execute so register updates can happen at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dreg_q <= '0;
      out_q  <= '0;
      oe_q   <= 1'b0;
    end else if (exec) begin
      unique case (op)
        OP_RD_DATA: begin
          out_q  <= dreg_q;
          dreg_q <= rdata;
          oe_q   <= page_hit;
        end
        OP_RD_ADDR: begin
          out_q <= addr[ADDR_W-1:DATA_W];
          oe_q  <= 1'b1;
        end
        OP_WR_ADDR: begin
          if (pair_hit) dreg_q <= rdata;
          oe_q <= 1'b0;
        end
        default: oe_q <= 1'b0;
      endcase
    end
  end

  assign data_o    = out_q;
  assign data_oe_o = ready_o && oe_q;
endmodule

// File: rtl/pbm_checker.sv
module pbm_checker
  import pbm_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int IW = 13
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          ce_ni,
  input logic          ready_o,
  input logic          data_oe_o,
  input logic [DW-1:0] data_i,
  input logic          exec,
  input op_e           op,
  input logic          pair_hit,
  input logic [AW-1:0] addr
);
  assert_oe_in_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> ready_o);

  assert_ready_on_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($past(tick_i) && !$past(ce_ni)));

  assert_ready_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && ce_ni) |=> !ready_o);

  assert_idle_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && $past(ce_ni)) |-> !ready_o);

  assert_rd_addr_shift_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && op == OP_RD_ADDR) |=> addr[AW-1:DW] == $past(addr[DW-1:0]));

  assert_wr_addr_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && op == OP_WR_ADDR && !pair_hit) |=> addr == {$past(addr[DW-1:0]), $past(data_i)});

  assert_incr_page_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && (op == OP_RD_DATA || op == OP_WR_DATA)) |=>
      (addr[AW-1:IW] == $past(addr[AW-1:IW])) &&
      (addr[IW-1:0] == IW'($past(addr[IW-1:0]) + IW'(1))));
endmodule

bind pbm_top pbm_checker #(.AW(ADDR_W), .DW(DATA_W), .IW(IDX_W)) i_pbm_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .ce_ni     (ce_ni),
  .ready_o   (ready_o),
  .data_oe_o (data_oe_o),
  .data_i    (data_i),
  .exec      (exec),
  .op        (op),
  .pair_hit  (pair_hit),
  .addr      (addr)
);

// File: tb/test_pbm_top.sv
module test_pbm_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 6144;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       ce_ni = 1'b1;
  logic       mode_addr_i = 1'b0;
  logic       mode_rd_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic [7:0] data_o;
  logic       data_oe_o;
  logic       ready_o;

  int n_chk = 0;
  int n_fail = 0;

  // bench model
  logic [15:0] m_a;
  logic [7:0]  m_dreg;
  bit          m_dv;
  bit          m_pair;
  logic [7:0]  bm [DEPTH];
  bit          bk [DEPTH];

  pbm_top i_pbm_top (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .ce_ni       (ce_ni),
    .mode_addr_i (mode_addr_i),
    .mode_rd_i   (mode_rd_i),
    .data_i      (data_i),
    .data_o      (data_o),
    .data_oe_o   (data_oe_o),
    .ready_o     (ready_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk_i);
      tc = (tc + 1) % 3;
      tick_i = (tc == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int fold(input logic [12:0] i);
    return (int'(i) >= DEPTH) ? int'(i) - DEPTH : int'(i);
  endfunction

  function automatic logic [15:0] inc(input logic [15:0] a);
    return {a[15:13], 13'(a[12:0] + 13'd1)};
  endfunction

  task automatic do_op(input logic m0, input logic m1, input logic [7:0] wb,
                       output logic [7:0] rb, output logic oe);
    int ticks;
    int guard;
    @(negedge clk_i);
    mode_addr_i = m0;
    mode_rd_i   = m1;
    data_i      = wb;
    ce_ni       = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    ticks = 0;
    guard = 0;
    while (!ready_o && guard < 200) begin
      @(posedge clk_i);
      if (tick_i) ticks++;
      @(negedge clk_i);
      guard++;
    end
    chk(ticks == 2, "R9 ticks to ready", ticks, 2);
    rb = data_o;
    oe = data_oe_o;
    ce_ni = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(!ready_o && !data_oe_o, "R9 ready drop", {ready_o, data_oe_o}, 0);
  endtask

  task automatic t_wa(input logic [7:0] b);
    logic [7:0] rb;
    logic oe;
    int f;
    do_op(1'b1, 1'b0, b, rb, oe);
    chk(oe == 1'b0, "R10 no drive on write", oe, 0);
    m_a = {m_a[7:0], b};
    if (m_pair) begin
      f = fold(m_a[12:0]);
      m_dreg = bm[f];
      m_dv = bk[f];
      m_a = inc(m_a);
      m_pair = 1'b0;
    end else begin
      m_pair = 1'b1;
    end
  endtask

  task automatic t_wd(input logic [7:0] b);
    logic [7:0] rb;
    logic oe;
    int f;
    do_op(1'b0, 1'b0, b, rb, oe);
    chk(oe == 1'b0, "R10 no drive on write", oe, 0);
    f = fold(m_a[12:0]);
    bm[f] = b;
    bk[f] = 1'b1;
    m_a = inc(m_a);
    m_pair = 1'b0;
  endtask

  task automatic t_rd(input string tag);
    logic [7:0] rb;
    logic oe;
    bit exp_oe;
    int f;
    do_op(1'b0, 1'b1, 8'h00, rb, oe);
    exp_oe = (m_a[15:13] == 3'd5);
    chk(oe == exp_oe, {tag, " R5 page gate"}, oe, exp_oe);
    if (exp_oe && m_dv) chk(rb == m_dreg, {tag, " R4 read data"}, rb, m_dreg);
    m_a = inc(m_a);
    f = fold(m_a[12:0]);
    m_dreg = bm[f];
    m_dv = bk[f];
    m_pair = 1'b0;
  endtask

  task automatic t_ra(input string tag);
    logic [7:0] rb;
    logic oe;
    do_op(1'b1, 1'b1, 8'h00, rb, oe);
    chk(oe == 1'b1, {tag, " R6 address drive"}, oe, 1);
    chk(rb == m_a[15:8], {tag, " R6 address byte"}, rb, m_a[15:8]);
    m_a[15:8] = m_a[7:0];
    m_pair = 1'b0;
  endtask

  task automatic pulse_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    m_a = '0;
    m_dreg = '0;
    m_dv = 1'b0;
    m_pair = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    m_a = '0; m_dreg = '0; m_dv = 1'b0; m_pair = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(!ready_o && !data_oe_o, "R1 reset outputs", {ready_o, data_oe_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!ready_o && !data_oe_o, "R1 idle outputs", {ready_o, data_oe_o}, 0);

    // load index 0x1FFF, increment wraps to 0 (R7), then fill 0..63 (R8)
    t_wa(8'h1F);
    t_wa(8'hFF);
    t_ra("R7 wrap");
    t_wa(8'h00);
    t_wa(8'h00);
    t_wa(8'h1F);
    t_wa(8'hFF);
    for (int i = 0; i < 64; i++) t_wd(8'((i * 7) + 3));

    // stream back on page 5 (R4, R5)
    t_wa(8'hA0);
    t_wa(8'h00);
    for (int i = 0; i < 63; i++) t_rd("R4 stream");

    // writes at index 8184..8191 fold to 2040..2047 (R8)
    t_wa(8'h1F);
    t_wa(8'hF7);
    for (int i = 0; i < 8; i++) t_wd(8'(8'hC0 + i));
    t_ra("R7 page kept after wrap");

    // reads across 8191 -> 0 keep page 5 (R7, R8)
    t_wa(8'hBF);
    t_wa(8'hFD);
    for (int i = 0; i < 4; i++) t_rd("R8 fold read");
    t_ra("R7 page field");

    // every page value: only page 5 drives on read-data (R5)
    for (int p = 0; p < 8; p++) begin
      t_wa({3'(p), 5'd0});
      t_wa(8'h00);
      t_rd("R5 sweep");
      t_ra("R5 increment despite page");
    end

    // address write after read-data opens a new pair (R3)
    t_wa(8'hA0);
    t_wa(8'h00);
    t_rd("R3 prior read");
    t_wa(8'hA0);
    t_wa(8'h00);
    t_ra("R3 pair after other op");
    t_ra("R3 pair after other op");

    // reset clears the pair flag (R1)
    t_wa(8'h55);
    pulse_reset();
    chk(!ready_o && !data_oe_o, "R1 reset outputs", {ready_o, data_oe_o}, 0);
    t_wa(8'hA0);
    t_wa(8'h00);
    t_ra("R1 pair flag cleared");
    t_ra("R1 pair flag cleared");

    // sweep of address bytes: shift, pair increment and readback (R2, R6)
    for (int v = 0; v < 256; v++) begin
      t_wa(8'(v));
      t_wa(8'(v) ^ 8'h5A);
      t_ra("R2 sweep");
      t_ra("R2 sweep");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule